// File: doc/BRIEF.md
# Pin edge interrupt detector

This block watches the synchronized levels of a port of input pins and raises a sticky flag for each pin whose level moves in the direction that pin has been configured to report. Each pin is configured on its own: an interrupt enable, a two-bit edge selection and an optional glitch filter that sits in front of the edge detector. Software clears flags by writing ones to the flag-clear strobe.

The configuration bits are changed through one-cycle strobe vectors. Enable and filter bits each have a set vector and a clear vector, so a write touches only the pins whose bits are one. The edge selection for all pins is loaded at once from a wide data bus. The flag vector and a single interrupt request line, the OR of all flags, are registered outputs.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset every flag and the request line are 0, every pin is disabled, every edge selection is 00 and every filter is off.
- R2: A one on `ie_set_i[n]` enables pin n and a one on `ie_clr_i[n]` disables it; when both are one in the same cycle the pin ends up enabled. A disabled pin never sets its flag.
- R3: Edge code 01 (bits 2n+1:2n of `mode_i`) reports rising edges only; with the filter off the flag is visible one clock edge after the new level is first sampled.
- R4: Edge code 10 reports falling edges only.
- R5: Edge code 00 reports both rising and falling edges.
- R6: Edge code 11 reports no edges.
- R7: A set flag stays set until a one is written to its bit of `flag_clr_i`; ones on other bits and zeros leave it unchanged.
- R8: When a reported edge and a clear of the same flag occur in the same cycle, the flag stays set.
- R9: With the filter on, a new level is accepted only after it has been sampled on 2 consecutive clock edges; a level lasting one cycle is ignored, and a lasting change sets the flag on the third clock edge after it appears.
- R10: Switching the filter on or off while the pin is stable produces no flag.
- R11: `irq_o` is 1 exactly when at least one flag bit is 1, in the same cycle as the flags.
- R12: Pins are independent: edges on several pins in one cycle each set only their own flag according to their own configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Synchronized pin levels |
| ie_set_i | input | NPINS | Write-one strobe: enable pin interrupt |
| ie_clr_i | input | NPINS | Write-one strobe: disable pin interrupt |
| gf_set_i | input | NPINS | Write-one strobe: turn filter on |
| gf_clr_i | input | NPINS | Write-one strobe: turn filter off |
| mode_we_i | input | 1 | Load edge selections from `mode_i` |
| mode_i | input | 2*NPINS | Edge selection, two bits per pin |
| flag_clr_i | input | NPINS | Write-one strobe: clear flags |
| flag_o | output | NPINS | Sticky interrupt flags |
| irq_o | output | 1 | OR of all flags |

## Verification
On every cycle the assertions check that a set flag persists unless cleared, that a disabled pin or a pin with code 11 cannot gain a flag, that the request line equals the OR of the flags, and that the filter output only ever moves to the level just sampled. The direction selection of each code, the one-cycle pulse rejection and three-edge latency of the filter, the precedence of an edge over a clear, the set-over-clear rule of the enable and the absence of a flag when the filter is toggled on a quiet pin are shown only by the bench's directed scenarios.

// File: rtl/pei_pkg.sv
package pei_pkg;
  typedef enum logic [1:0] {
    EDGE_ANY  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/pei_cfg.sv
module pei_cfg #(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   ie_set_i,
  input  logic [NPINS-1:0]   ie_clr_i,
  input  logic [NPINS-1:0]   gf_set_i,
  input  logic [NPINS-1:0]   gf_clr_i,
  input  logic               mode_we_i,
  input  logic [2*NPINS-1:0] mode_i,
  output logic [NPINS-1:0]   ie_o,
  output logic [NPINS-1:0]   gf_o,
  output logic [2*NPINS-1:0] mode_o
);
  logic [NPINS-1:0]   ie_q, gf_q;
  logic [2*NPINS-1:0] mode_q;

  // set wins over clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= '0;
      gf_q   <= '0;
      mode_q <= '0;
    end else begin
      ie_q <= (ie_q & ~ie_clr_i) | ie_set_i;
      gf_q <= (gf_q & ~gf_clr_i) | gf_set_i;
      if (mode_we_i) mode_q <= mode_i;
    end
  end

  assign ie_o   = ie_q;
  assign gf_o   = gf_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/pei_filter.sv
module pei_filter #(
  parameter int NPINS    = 32,
  parameter int FILT_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] gf_i,
  output logic [NPINS-1:0] lvl_o
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic          filt_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        filt_q <= 1'b0;
        cnt_q  <= '0;
      end else if (!gf_i[n]) begin
        // track the pin so that turning the filter on makes no step
        filt_q <= pin_i[n];
        cnt_q  <= '0;
      end else if (pin_i[n] != filt_q) begin
        if (cnt_q == CNT_LAST) begin
          filt_q <= pin_i[n];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end

    assign lvl_o[n] = gf_i[n] ? filt_q : pin_i[n];

    // R9
    filt_follows_pin_chk: assert property (@(posedge clk) disable iff (rst)
      (!$stable(filt_q)) |-> (filt_q == $past(pin_i[n])));
  end
endmodule

// File: rtl/pei_detect.sv
module pei_detect
  import pei_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   lvl_i,
  input  logic [NPINS-1:0]   ie_i,
  input  logic [2*NPINS-1:0] mode_i,
  input  logic [NPINS-1:0]   flag_clr_i,
  output logic [NPINS-1:0]   flag_o,
  output logic               irq_o
);
  logic [NPINS-1:0] prev_q, hit, flag_d, flag_q;
  logic             irq_q;

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic rise, fall;
    assign rise = lvl_i[n] & ~prev_q[n];
    assign fall = ~lvl_i[n] & prev_q[n];

    always_comb begin
      case (edge_mode_e'(mode_i[2*n +: 2]))
        EDGE_ANY:  hit[n] = ie_i[n] & (rise | fall);
        EDGE_RISE: hit[n] = ie_i[n] & rise;
        EDGE_FALL: hit[n] = ie_i[n] & fall;
        default:   hit[n] = 1'b0;
      endcase
    end

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (flag_q[n] && !flag_clr_i[n]) |=> flag_q[n]);
    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!ie_i[n] && !flag_q[n]) |=> !flag_q[n]);
    // R6
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_i[2*n +: 2] == 2'b11 && !flag_q[n]) |=> !flag_q[n]);
  end

  // edge beats a simultaneous clear
  assign flag_d = (flag_q & ~flag_clr_i) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= flag_d;
      irq_q  <= |flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R11
  irq_matches_flags_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|flag_q));
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
  parameter int NPINS    = 32,
  parameter int FILT_LEN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   pin_i,
  input  logic [NPINS-1:0]   ie_set_i,
  input  logic [NPINS-1:0]   ie_clr_i,
  input  logic [NPINS-1:0]   gf_set_i,
  input  logic [NPINS-1:0]   gf_clr_i,
  input  logic               mode_we_i,
  input  logic [2*NPINS-1:0] mode_i,
  input  logic [NPINS-1:0]   flag_clr_i,
  output logic [NPINS-1:0]   flag_o,
  output logic               irq_o
);
  logic [NPINS-1:0]   ie, gf, lvl;
  logic [2*NPINS-1:0] mode;

  pei_cfg #(.NPINS(NPINS)) u_cfg (
    .clk(clk), .rst(rst),
    .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
    .gf_set_i(gf_set_i), .gf_clr_i(gf_clr_i),
    .mode_we_i(mode_we_i), .mode_i(mode_i),
    .ie_o(ie), .gf_o(gf), .mode_o(mode)
  );

  pei_filter #(.NPINS(NPINS), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .pin_i(pin_i), .gf_i(gf), .lvl_o(lvl)
  );

  pei_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst(rst), .lvl_i(lvl), .ie_i(ie), .mode_i(mode),
    .flag_clr_i(flag_clr_i), .flag_o(flag_o), .irq_o(irq_o)
  );
endmodule

// File: tb/sim_pin_edge_irq.sv
module sim_pin_edge_irq;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] pin_i, ie_set_i, ie_clr_i, gf_set_i, gf_clr_i, flag_clr_i;
  logic         mode_we_i;
  logic [2*N-1:0] mode_i;
  logic [N-1:0] flag_o;
  logic         irq_o;

  int vectors = 0;
  int errors  = 0;
  logic [2*N-1:0] modes = '0;

  always #10 clk = ~clk;

  pin_edge_irq #(.NPINS(N), .FILT_LEN(2)) u0 (
    .clk(clk), .rst(rst), .pin_i(pin_i),
    .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
    .gf_set_i(gf_set_i), .gf_clr_i(gf_clr_i),
    .mode_we_i(mode_we_i), .mode_i(mode_i),
    .flag_clr_i(flag_clr_i), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
    ie_set_i = '0; ie_clr_i = '0; gf_set_i = '0; gf_clr_i = '0;
    flag_clr_i = '0; mode_we_i = 1'b0;
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input int p, input logic [1:0] m);
    modes[2*p +: 2] = m;
    mode_i = modes; mode_we_i = 1'b1;
    tick();
  endtask

  task automatic enable(input int p);
    ie_set_i[p] = 1'b1; tick();
  endtask

  task automatic clear_all;
    flag_clr_i = '1; tick();
    chk("R7 clear all", flag_o, '0);
  endtask

  task automatic t_reset;
    chk("R1 flags", flag_o, '0);
    chk("R1 irq", {31'b0, irq_o}, '0);
    pin_i[0] = 1'b1; tick();     // disabled pins, mode 00
    chk("R1 disabled after reset", flag_o, '0);
    pin_i[0] = 1'b0; tick();
  endtask

  task automatic t_rise;
    set_mode(3, 2'b01); enable(3);
    pin_i[3] = 1'b1; tick();
    chk("R3 rise sets", flag_o, 32'h8);
    chk("R11 irq up", {31'b0, irq_o}, 32'h1);
    pin_i[3] = 1'b0; tick(2);
    chk("R3 fall ignored, R7 sticky", flag_o, 32'h8);
    flag_clr_i[4] = 1'b1; tick();
    chk("R7 other-bit clear", flag_o, 32'h8);
    flag_clr_i[3] = 1'b1; tick();
    chk("R7 clear", flag_o, '0);
    chk("R11 irq down", {31'b0, irq_o}, '0);
  endtask

  task automatic t_fall;
    set_mode(5, 2'b10); enable(5);
    pin_i[5] = 1'b1; tick(2);
    chk("R4 rise ignored", flag_o, '0);
    pin_i[5] = 1'b0; tick();
    chk("R4 fall sets", flag_o, 32'h20);
    clear_all();
  endtask

  task automatic t_any;
    set_mode(7, 2'b00); enable(7);
    pin_i[7] = 1'b1; tick();
    chk("R5 rise", flag_o, 32'h80);
    clear_all();
    pin_i[7] = 1'b0; tick();
    chk("R5 fall", flag_o, 32'h80);
    clear_all();
  endtask

  task automatic t_reserved;
    set_mode(9, 2'b11); enable(9);
    pin_i[9] = 1'b1; tick();
    pin_i[9] = 1'b0; tick();
    chk("R6 code 11 silent", flag_o, '0);
  endtask

  task automatic t_enable;
    pin_i[11] = 1'b1; tick(); pin_i[11] = 1'b0; tick();
    chk("R2 disabled pin", flag_o, '0);
    enable(12); ie_clr_i[12] = 1'b1; tick();
    pin_i[12] = 1'b1; tick(); pin_i[12] = 1'b0; tick();
    chk("R2 after clear", flag_o, '0);
    ie_set_i[13] = 1'b1; ie_clr_i[13] = 1'b1; tick();
    pin_i[13] = 1'b1; tick();
    chk("R2 set wins", flag_o, 32'h2000);
    clear_all();
  endtask

  task automatic t_filter;
    enable(14); gf_set_i[14] = 1'b1; tick();
    pin_i[14] = 1'b1; tick();
    pin_i[14] = 1'b0; tick(3);
    chk("R9 pulse rejected", flag_o, '0);
    pin_i[14] = 1'b1; tick();
    chk("R9 edge1", flag_o, '0);
    tick();
    chk("R9 edge2", flag_o, '0);
    tick();
    chk("R9 edge3", flag_o, 32'h4000);
    clear_all();
    gf_clr_i[14] = 1'b1; tick(2);
    chk("R10 filter off quiet", flag_o, '0);
    gf_set_i[14] = 1'b1; tick(2);
    chk("R10 filter on quiet", flag_o, '0);
    enable(15);
    pin_i[15] = 1'b1; tick();
    pin_i[15] = 1'b0; tick();
    chk("R9 unfiltered pulse seen", flag_o, 32'h8000);
    clear_all();
  endtask

  task automatic t_race;
    pin_i[3] = 1'b1; tick();
    chk("R8 setup", flag_o, 32'h8);
    pin_i[3] = 1'b0; tick();
    pin_i[3] = 1'b1; flag_clr_i[3] = 1'b1; tick();
    chk("R8 edge beats clear", flag_o, 32'h8);
    clear_all();
  endtask

  task automatic t_multi;
    set_mode(0, 2'b01); enable(0);
    set_mode(1, 2'b10); enable(1);
    pin_i[1] = 1'b1; tick(2);
    pin_i[0] = 1'b1; pin_i[1] = 1'b0; pin_i[3] = 1'b0; pin_i[9] = 1'b1;
    tick();
    chk("R12 independent pins", flag_o, 32'h3);
    clear_all();
  endtask

  initial begin
    pin_i = '0; ie_set_i = '0; ie_clr_i = '0; gf_set_i = '0; gf_clr_i = '0;
    flag_clr_i = '0; mode_we_i = 1'b0; mode_i = '0;
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick();
    t_reset();
    t_rise();
    t_fall();
    t_any();
    t_reserved();
    t_enable();
    t_filter();
    t_race();
    t_multi();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule